// File: doc/BRIEF.md
# Serial Control Port with Latched Interrupt

This block is the control-plane slave port of a line transceiver. A host drives a chip select, a serial clock and a data line. Each transaction is a fixed-length frame: a command byte followed by a data byte, both sent most significant bit first. A completed write frame produces a one-cycle write strobe that carries an address and a data byte to the register file. A read of the status address shifts a status byte back out. This status byte is snapshotted when the transaction opens. The status output is only driven while chip select is low.

The block runs on its own control-domain clock. That clock is unrelated to the data-path bit clock. The serial pins are oversampled through two-flop synchronizers, and edges are detected on the synchronized copies. The line side reports each status change by flipping a toggle line. That toggle crosses into the control domain and sets a sticky interrupt request. The request drives an open-drain pin low, modelled as a drive-low enable. The request is cleared only by a completed, correctly framed read of the status address. A set that lands in the same cycle as a clear wins.

Top module: `serial_ctl_port`

## Requirements
- R1: After reset the write strobe is low, the interrupt drive-low enable is low and the serial data output value is 0.
- R2: The serial output enable `sdo_oe` equals the inverse of `csn` at all times, so the output is released whenever chip select is high.
- R3: A frame is 16 serial clock rising edges while `csn` is low, sampled MSB first. Bit 15 set means read and clear means write, bits 14..8 are the address and bits 7..0 the data. A 16-bit write frame gives `wr_stb` high for exactly one clock, with `wr_addr` and `wr_data` valid, 3 clocks after the `csn` rising edge.
- R4: A frame with fewer or more than 16 rising edges is discarded: no strobe, and no interrupt clear.
- R5: Serial clock and data activity while `csn` is high has no effect: no strobe, no output change, and the next frame decodes normally.
- R6: In a read of address 0 (the status address), `sdo` presents status bit 7 down to bit 0. Each bit appears 3 clocks after the serial clock falling edges that follow rising edges 8 through 15. At every other point of the frame, and for reads of other addresses, `sdo` is 0.
- R7: The status byte that is shifted out is the value of `status_in` captured 3 clocks after `csn` falls. Later changes of `status_in` do not alter the byte in flight.
- R8: Each transition of `evt_tgl` sets `irq_pull` 3 clocks later, and `irq_pull` stays set until cleared.
- R9: `irq_pull` clears 3 clocks after the `csn` rising edge that ends a complete 16-bit status read. Writes, partial frames and reads of other addresses do not clear it.
- R10: When a set event and a status-read clear fall in the same clock, `irq_pull` ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csn | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, asynchronous to clk |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Output enable for sdo |
| status_in | input | DATA_W | Current line status byte |
| evt_tgl | input | 1 | Toggles once per status change |
| irq_pull | output | 1 | Drive-low enable of the open-drain interrupt pin |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | CMD_W-1 | Write address |
| wr_data | output | DATA_W | Write data |

## Verification
Every result that passes through the synchronizers is due 3 clocks after the bench changes the input that causes it. This covers the write strobe, each `sdo` bit, the status snapshot, and the interrupt set and clear. The output enable is combinational and due in the same cycle. The bench drives inputs on falling clock edges and records the cycle number of each stimulus. It queues the expected strobe, interrupt change and output bit at that cycle plus 3. A quarter period after each rising edge it compares every output against the value scheduled for that cycle.

// File: rtl/serial_ctl_port.sv
module serial_ctl_port #(
  parameter int CMD_W = 8,
  parameter int DATA_W = 8,
  parameter logic [CMD_W-2:0] STAT_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn,
  input  logic              sck,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic [DATA_W-1:0] status_in,
  input  logic              evt_tgl,
  output logic              irq_pull,
  output logic              wr_stb,
  output logic [CMD_W-2:0]  wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  localparam int FRAME = CMD_W + DATA_W;
  localparam int CNT_W = $clog2(FRAME + 2);
  localparam logic [CNT_W-1:0] CNT_CMD  = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME + 1);

  logic [1:0] cs_sy, ck_sy, di_sy, ev_sy;
  logic       cs_q, ck_q, ev_q;
  logic       cs_s, ck_s, di_s, ev_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy <= 2'b11;
      ck_sy <= '0;
      di_sy <= '0;
      ev_sy <= '0;
      cs_q  <= 1'b1;
      ck_q  <= 1'b0;
      ev_q  <= 1'b0;
    end else begin
      cs_sy <= {cs_sy[0], csn};
      ck_sy <= {ck_sy[0], sck};
      di_sy <= {di_sy[0], sdi};
      ev_sy <= {ev_sy[0], evt_tgl};
      cs_q  <= cs_s;
      ck_q  <= ck_s;
      ev_q  <= ev_s;
    end
  end

  assign cs_s = cs_sy[1];
  assign ck_s = ck_sy[1];
  assign di_s = di_sy[1];
  assign ev_s = ev_sy[1];

  logic cs_fall, cs_rise, ck_rise, ck_fall, ev_pulse;
  assign cs_fall  = cs_q & ~cs_s;
  assign cs_rise  = ~cs_q & cs_s;
  assign ck_rise  = ~cs_s & ck_s & ~ck_q;
  assign ck_fall  = ~cs_s & ~ck_s & ck_q;
  assign ev_pulse = ev_s ^ ev_q;

  logic [CNT_W-1:0]  cnt;
  logic [FRAME-1:0]  sr;
  logic [CMD_W-1:0]  cmd;
  logic [DATA_W-1:0] snap;
  logic              sdo_q;
  logic              full, is_rd, st_rd, st_clr;

  assign full   = (cnt == CNT_FULL);
  assign is_rd  = cmd[CMD_W-1];
  assign st_rd  = is_rd && (cmd[CMD_W-2:0] == STAT_ADDR);
  assign st_clr = cs_rise && full && st_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      sr    <= '0;
      cmd   <= '0;
      snap  <= '0;
      sdo_q <= 1'b0;
    end else if (cs_fall) begin
      cnt   <= '0;
      cmd   <= '0;
      snap  <= status_in;
      sdo_q <= 1'b0;
    end else begin
      if (ck_rise) begin
        if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
        if (cnt < CNT_FULL) sr <= {sr[FRAME-2:0], di_s};
        if (cnt == CNT_LAST) cmd <= {sr[CMD_W-2:0], di_s};
      end
      if (ck_fall) begin
        if (cnt >= CNT_CMD && cnt < CNT_FULL && st_rd) begin
          sdo_q <= snap[DATA_W-1];
          snap  <= {snap[DATA_W-2:0], 1'b0};
        end else begin
          sdo_q <= 1'b0;
        end
      end
    end
  end

  logic              irq_q, stb_q;
  logic [CMD_W-2:0]  addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      stb_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (ev_pulse)    irq_q <= 1'b1;
      else if (st_clr) irq_q <= 1'b0;
      stb_q <= cs_rise && full && !is_rd;
      if (cs_rise && full && !is_rd) begin
        addr_q <= cmd[CMD_W-2:0];
        data_q <= sr[DATA_W-1:0];
      end
    end
  end

  assign sdo      = sdo_q;
  assign sdo_oe   = ~csn;
  assign irq_pull = irq_q;
  assign wr_stb   = stb_q;
  assign wr_addr  = addr_q;
  assign wr_data  = data_q;

endmodule

// File: rtl/serial_ctl_port_chk.sv
module serial_ctl_port_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_stb,
  input logic irq_pull,
  input logic ev_pulse,
  input logic st_clr,
  input logic full
);

  a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  a_r4_strobe_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(full));

  a_r8_irq_rise_from_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pull) |-> $past(ev_pulse));

  a_r9_irq_fall_from_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_pull) |-> ($past(st_clr) && !$past(ev_pulse)));

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pulse |=> irq_pull);

endmodule

bind serial_ctl_port serial_ctl_port_chk u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .wr_stb(wr_stb),
  .irq_pull(irq_pull),
  .ev_pulse(ev_pulse),
  .st_clr(st_clr),
  .full(full)
);

// File: tb/sim_serial_ctl_port.sv
module sim_serial_ctl_port;
  localparam int CLK_P = 10;
  localparam int PH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic csn = 1'b1, sck = 1'b0, sdi = 1'b0, evt = 1'b0;
  logic [7:0] status_in = 8'h00;
  logic sdo, sdo_oe, irq_pull, wr_stb;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;

  serial_ctl_port u0 (
    .clk(clk), .rst_n(rst_n), .csn(csn), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .status_in(status_in), .evt_tgl(evt),
    .irq_pull(irq_pull), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct { int at; logic [6:0] a; logic [7:0] d; } wr_t;
  wr_t wq[$];
  int set_q[$];
  int clr_q[$];
  bit sdo_at[int];

  int cyc = 0, errs = 0, checks = 0, n_wr = 0;
  bit exp_irq = 0, exp_sdo = 0, done = 0;
  string tag = "R1";

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s cycle %0d: actual=%0h expected=%0h", rq, cyc, act, exp);
    end
  endtask

  always begin
    @(posedge clk);
    cyc++;
    #(CLK_P/4);
    begin
      bit s, c, ew;
      s = 0; c = 0; ew = 0;
      while (set_q.size() > 0 && set_q[0] <= cyc) begin s = 1; void'(set_q.pop_front()); end
      while (clr_q.size() > 0 && clr_q[0] <= cyc) begin c = 1; void'(clr_q.pop_front()); end
      if (s) exp_irq = 1;          // R10: set wins over clear
      else if (c) exp_irq = 0;
      if (sdo_at.exists(cyc)) exp_sdo = sdo_at[cyc];
      if (rst_n) begin
        chk(sdo_oe == ~csn, "R2", sdo_oe, ~csn);
        chk(irq_pull == exp_irq, tag, irq_pull, exp_irq);
        if (sdo_oe) chk(sdo == exp_sdo, tag, sdo, exp_sdo);
        if (wq.size() > 0 && wq[0].at == cyc) begin
          ew = 1;
          chk(wr_addr == wq[0].a, tag, wr_addr, wq[0].a);
          chk(wr_data == wq[0].d, tag, wr_data, wq[0].d);
          void'(wq.pop_front());
        end
        chk(wr_stb == ew, tag, wr_stb, ew);
        if (wr_stb) n_wr++;
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input int nbits, input logic [15:0] w, input bit flip_stat, input bit ev_end);
    logic [7:0] snap;
    bit strd;
    strd = w[15] && (w[14:8] == 7'h00);
    @(negedge clk);
    csn = 0;
    snap = status_in;
    sdo_at[cyc+3] = 0;
    step(PH);
    for (int i = 0; i < nbits; i++) begin
      int k;
      sdi = (i < 16) ? w[15-i] : 1'b0;
      step(PH);
      sck = 1;
      step(PH);
      sck = 0;
      k = i + 1;
      sdo_at[cyc+3] = (k >= 8 && k < 16 && strd) ? snap[15-k] : 1'b0;
      if (flip_stat && i == 3) status_in = ~status_in;
    end
    step(PH);
    csn = 1;
    if (nbits == 16 && !w[15]) wq.push_back('{cyc+3, w[14:8], w[7:0]});
    if (nbits == 16 && strd) clr_q.push_back(cyc+3);
    if (ev_end) begin evt = ~evt; set_q.push_back(cyc+3); end
    step(PH+2);
  endtask

  task automatic toggle_evt();
    @(negedge clk);
    evt = ~evt;
    set_q.push_back(cyc+3);
    step(6);
  endtask

  initial begin
    int base;
    step(3);
    tag = "R1";
    chk(wr_stb == 0, "R1", wr_stb, 0);
    chk(irq_pull == 0, "R1", irq_pull, 0);
    chk(sdo == 0, "R1", sdo, 0);
    rst_n = 1;
    step(4);

    tag = "R3";
    xfer(16, {1'b0, 7'h05, 8'hA5}, 0, 0);
    xfer(16, {1'b0, 7'h7F, 8'h3C}, 0, 0);
    chk(n_wr == 2, "R3", n_wr, 2);

    tag = "R4";
    base = n_wr;
    xfer(10, {1'b0, 7'h11, 8'hFF}, 0, 0);
    xfer(18, {1'b0, 7'h22, 8'h0F}, 0, 0);
    chk(n_wr == base, "R4", n_wr, base);

    tag = "R5";
    base = n_wr;
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      sck = ~sck;
      sdi = j[1];
      step(PH-1);
    end
    sck = 0;
    step(6);
    chk(n_wr == base, "R5", n_wr, base);
    xfer(16, {1'b0, 7'h33, 8'h96}, 0, 0);
    chk(n_wr == base + 1, "R5", n_wr, base + 1);

    tag = "R8";
    toggle_evt();
    chk(irq_pull == 1, "R8", irq_pull, 1);

    tag = "R9";
    xfer(16, {1'b1, 7'h03, 8'h00}, 0, 0);
    xfer(16, {1'b0, 7'h00, 8'h55}, 0, 0);
    xfer(12, {1'b1, 7'h00, 8'h00}, 0, 0);
    chk(irq_pull == 1, "R9", irq_pull, 1);

    tag = "R6";
    status_in = 8'hC6;
    step(2);
    xfer(16, {1'b1, 7'h00, 8'h00}, 0, 0);
    chk(irq_pull == 0, "R9", irq_pull, 0);

    tag = "R7";
    status_in = 8'h5A;
    step(2);
    xfer(16, {1'b1, 7'h00, 8'h00}, 1, 0);

    tag = "R10";
    toggle_evt();
    xfer(16, {1'b1, 7'h00, 8'h00}, 0, 1);
    chk(irq_pull == 1, "R10", irq_pull, 1);
    tag = "R9";
    xfer(16, {1'b1, 7'h00, 8'h00}, 0, 0);
    chk(irq_pull == 0, "R9", irq_pull, 0);

    step(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule